// File: doc/BRIEF.md
# I/O Address Decoder with Switch-Set Base

This block decodes a 10-bit I/O address bus for a board that carries 1, 2, 4 or 8 three-port parallel controllers, each taking four consecutive register locations. A bank of switches supplies the base address. The upper address bits are compared with the switch bits above an alignment boundary. That boundary grows with the controller count, so the board always covers a naturally aligned window of four times the controller count.

When a read or write strobe is active and the address falls inside the window, the decoder raises a board-hit flag. It also drives exactly one controller select and passes the two-bit register offset through to the controllers. A jumper input can enable a wait-state request. The request holds the bus not-ready for a fixed number of clocks at the start of each access that hits the board. Bus cycles that go elsewhere are never stretched.

Top module: `io_addr_decoder`

## Requirements
- R1: `board_hit` is high exactly when (`io_rd` or `io_wr`) is high and `io_addr[9:K]` equals `sw_base[9:K]`, where K = 2 + log2(`N_CTRL`). K is 2, 3, 4 and 5 for 1, 2, 4 and 8 controllers.
- R2: Bits `sw_base[K-1:0]` take no part in the compare. A misaligned switch setting decodes the aligned window that contains it.
- R3: The board answers exactly 4 × `N_CTRL` consecutive addresses. The first address past the window produces no hit.
- R4: While `board_hit` is high, `ctrl_sel` is one-hot with bit `io_addr[K-1:2]` set. Bit 0 is always the one set when `N_CTRL` = 1. While `board_hit` is low, `ctrl_sel` is all zero.
- R5: An address inside the window with both strobes low gives no select and no hit.
- R6: `reg_ofs` equals `io_addr[1:0]` while `board_hit` is high, and is 0 otherwise.
- R7: With `wait_en` low, `wait_req` stays low in every cycle.
- R8: `wait_req` is never high while `board_hit` is low.
- R9: With `wait_en` high, `wait_req` is high in the first `WAIT_CYC` (default 2) clock cycles of an unbroken run of `board_hit`, counting the cycle in which the hit begins. It is low for the rest of that run. A run begins again after `board_hit` has been low across at least one rising clock edge.
- R10: With the switches set to the default base 0x300 and `N_CTRL` = 2, the board responds at 0x300 through 0x307.
- R11: After reset, with both strobes low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock for the wait-state counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address bus |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| sw_base | input | ADDR_W | Base switch bank; a set bit requires the address bit to be 1 |
| wait_en | input | 1 | Wait-state jumper; high enables stretching |
| ctrl_sel | output | N_CTRL | One-hot controller select |
| reg_ofs | output | 2 | Register offset inside the selected controller |
| board_hit | output | 1 | Strobed access falls inside the board window |
| wait_req | output | 1 | Bus not-ready request |

## Verification
The hardest case to reach is the wait-state count across back-to-back hits. A run of hits that changes address, and even moves between controllers, must not restart the two-cycle stretch. A break of a single cycle must restart it. Random vectors are held for one clock each, with half of the addresses drawn inside the switch window. This produces long unbroken hit runs that cross controller boundaries, and a bench-side run counter predicts the request. Directed steps cover the misaligned switch setting and the address one past the window, checked on a 2-controller and an 8-controller instance at the same time.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

   // Switch setting used when the board is shipped.
   localparam logic [9:0] BASE_DEFAULT = 10'h300;

   // Each controller spans four register locations.
   localparam int unsigned OFS_W = 2;

   // Number of low address bits left out of the base compare.
   function automatic int unsigned align_bits(input int unsigned n_ctrl);
      return OFS_W + $clog2(n_ctrl);
   endfunction

endpackage

// File: rtl/io_dec_match.sv
module io_dec_match #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned ALIGN  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] sw,
   input  logic              strobe,
   output logic              hit
);
   // Only the bits at or above the boundary take part in the compare.
   localparam logic [ADDR_W-1:0] CMP_MASK = ~((ADDR_W'(1) << ALIGN) - ADDR_W'(1));

   logic [ADDR_W-1:0] diff;

   always_comb begin
      diff = (addr ^ sw) & CMP_MASK;
      hit  = strobe & ~(|diff);
   end
endmodule

// File: rtl/io_dec_sel.sv
module io_dec_sel #(
   parameter int unsigned N_CTRL = 2,
   parameter int unsigned ALIGN  = 3
) (
   input  logic [ALIGN-1:0]  low_addr,
   input  logic              hit,
   output logic [N_CTRL-1:0] sel,
   output logic [1:0]        ofs
);
   assign ofs = hit ? low_addr[1:0] : 2'b00;

   generate
      if (N_CTRL == 1) begin : g_single
         assign sel = hit;
      end else begin : g_multi
         localparam int unsigned IW = ALIGN - 2;
         logic [IW-1:0] idx;
         assign idx = low_addr[ALIGN-1:2];
         for (genvar i = 0; i < N_CTRL; i++) begin : g_line
            assign sel[i] = hit && (idx == IW'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/io_dec_wait.sv
module io_dec_wait #(
   parameter int unsigned WAIT_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic en,
   output logic req
);
   generate
      if (WAIT_CYC == 0) begin : g_none
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ hit ^ en;
         assign req = 1'b0;
      end else begin : g_count
         localparam int unsigned CW = $clog2(WAIT_CYC + 1);
         localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);
         logic [CW-1:0] cnt;

         // Counts clock edges seen inside the current hit run, saturating.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!hit) begin
               cnt <= '0;
            end else if (cnt != LIMIT) begin
               cnt <= cnt + CW'(1);
            end
         end

         assign req = en & hit & (cnt < LIMIT);
      end
   endgenerate
endmodule

// File: rtl/io_addr_decoder.sv
module io_addr_decoder
   import io_dec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned N_CTRL   = 2,
   parameter int unsigned WAIT_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] sw_base,
   input  logic              wait_en,
   output logic [N_CTRL-1:0] ctrl_sel,
   output logic [1:0]        reg_ofs,
   output logic              board_hit,
   output logic              wait_req
);
   localparam int unsigned ALIGN = align_bits(N_CTRL);

   generate
      if (!(N_CTRL == 1 || N_CTRL == 2 || N_CTRL == 4 || N_CTRL == 8)) begin : g_bad_n
         $error("io_addr_decoder: N_CTRL must be 1, 2, 4 or 8");
      end
      if (ADDR_W <= ALIGN) begin : g_bad_w
         $error("io_addr_decoder: ADDR_W too small for the controller window");
      end
      if (WAIT_CYC > 15) begin : g_bad_wait
         $error("io_addr_decoder: WAIT_CYC above 15 is not supported");
      end
   endgenerate

   logic hit;

   io_dec_match #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_match (
      .addr   (io_addr),
      .sw     (sw_base),
      .strobe (io_rd | io_wr),
      .hit    (hit)
   );

   io_dec_sel #(.N_CTRL(N_CTRL), .ALIGN(ALIGN)) u_sel (
      .low_addr (io_addr[ALIGN-1:0]),
      .hit      (hit),
      .sel      (ctrl_sel),
      .ofs      (reg_ofs)
   );

   io_dec_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .en    (wait_en),
      .req   (wait_req)
   );

   assign board_hit = hit;
endmodule

// File: rtl/io_addr_decoder_chk.sv
module io_addr_decoder_chk #(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned N_CTRL   = 2,
   parameter int unsigned WAIT_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_rd,
   input logic              io_wr,
   input logic              wait_en,
   input logic [N_CTRL-1:0] ctrl_sel,
   input logic [1:0]        reg_ofs,
   input logic              board_hit,
   input logic              wait_req
);
   // Consecutive cycles of wait_req seen at previous edges, saturating.
   logic [7:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run <= '0;
      else if (!wait_req)      run <= '0;
      else if (run != 8'hFF)   run <= run + 8'd1;
   end

   a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_sel));

   a_r4_hit_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
      board_hit |-> ($countones(ctrl_sel) == 1));

   a_r4_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !board_hit |-> (ctrl_sel == '0));

   a_r5_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (|ctrl_sel) |-> (io_rd || io_wr));

   a_r6_ofs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !board_hit |-> (reg_ofs == 2'b00));

   a_r7_no_wait_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_en |-> !wait_req);

   a_r8_wait_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> board_hit);

   a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> (run < 8'(WAIT_CYC)));

   generate
      if (WAIT_CYC > 0) begin : g_start
         a_r9_wait_start: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(board_hit) && wait_en) |-> wait_req);
      end
   endgenerate
endmodule

bind io_addr_decoder io_addr_decoder_chk #(
   .ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .WAIT_CYC(WAIT_CYC)
) u_chk (.*);

// File: tb/tb_io_addr_decoder.sv
module tb_io_addr_decoder;
   import io_dec_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] io_addr = '0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [9:0] sw_base = BASE_DEFAULT;
   logic       wait_en = 1'b0;

   logic [1:0] sel2;
   logic [1:0] ofs2;
   logic       hit2, wr2;
   logic [7:0] sel8;
   logic [1:0] ofs8;
   logic       hit8, wr8;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   int run2 = 0;
   int run8 = 0;

   always #10 clk = ~clk;

   io_addr_decoder #(.ADDR_W(10), .N_CTRL(2), .WAIT_CYC(2)) dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .sw_base(sw_base), .wait_en(wait_en), .ctrl_sel(sel2), .reg_ofs(ofs2),
      .board_hit(hit2), .wait_req(wr2));

   io_addr_decoder #(.ADDR_W(10), .N_CTRL(8), .WAIT_CYC(2)) dut8 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .sw_base(sw_base), .wait_en(wait_en), .ctrl_sel(sel8), .reg_ofs(ofs8),
      .board_hit(hit8), .wait_req(wr8));

   function automatic bit f_hit(input logic [9:0] a, input logic [9:0] s,
                                input bit rd, input bit wr, input int al);
      return (rd || wr) && ((a >> al) == (s >> al));
   endfunction

   function automatic logic [31:0] f_sel(input logic [9:0] a, input bit h,
                                         input int al);
      if (!h) return 32'd0;
      return 32'd1 << ((a >> 2) & ((32'd1 << (al - 2)) - 32'd1));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (addr=%0h sw=%0h rd=%0b wr=%0b en=%0b)",
                  tag, act, exp, io_addr, sw_base, io_rd, io_wr, wait_en);
      end
   endtask

   task automatic drive(input logic [9:0] a, input bit rd, input bit wr);
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr;
      #5;
   endtask

   task automatic hold();
      @(negedge clk);
      #5;
   endtask

   // Compare both instances against the model for the present inputs.
   task automatic check_all(input string tag);
      bit h2, h8;
      h2 = f_hit(io_addr, sw_base, io_rd, io_wr, 3);
      h8 = f_hit(io_addr, sw_base, io_rd, io_wr, 5);
      chk({tag, " R1 hit2"}, 32'(hit2), 32'(h2));
      chk({tag, " R1 hit8"}, 32'(hit8), 32'(h8));
      chk({tag, " R4 sel2"}, 32'(sel2), f_sel(io_addr, h2, 3));
      chk({tag, " R4 sel8"}, 32'(sel8), f_sel(io_addr, h8, 5));
      chk({tag, " R6 ofs2"}, 32'(ofs2), h2 ? 32'(io_addr[1:0]) : 32'd0);
      chk({tag, " R6 ofs8"}, 32'(ofs8), h8 ? 32'(io_addr[1:0]) : 32'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R11: reset state with strobes idle.
      #25;
      chk("R11 sel2 in reset", 32'(sel2), 32'd0);
      chk("R11 wait in reset", 32'(wr2), 32'd0);
      rst_n = 1'b1;
      hold();
      chk("R11 hit2 after reset", 32'(hit2), 32'd0);
      chk("R11 sel8 after reset", 32'(sel8), 32'd0);
      chk("R11 ofs2 after reset", 32'(ofs2), 32'd0);

      // R10, R1, R4, R6: default base, every location of the 2-controller window.
      for (int k = 0; k < 8; k++) begin
         drive(10'h300 + 10'(k), k[0], !k[0]);
         chk("R10 default window hit", 32'(hit2), 32'd1);
         check_all("R10");
      end

      // R3: one past the 2-controller window, still inside the 8-controller one.
      drive(10'h308, 1'b1, 1'b0);
      chk("R3 past window n2", 32'(hit2), 32'd0);
      chk("R3 inside window n8", 32'(hit8), 32'd1);
      chk("R4 n8 select index 2", 32'(sel8), 32'h04);
      drive(10'h320, 1'b1, 1'b0);
      chk("R3 past window n8", 32'(hit8), 32'd0);
      drive(10'h2FF, 1'b0, 1'b1);
      chk("R3 below window n2", 32'(hit2), 32'd0);

      // R5: matching address, strobes low.
      drive(10'h305, 1'b0, 1'b0);
      chk("R5 no strobe hit", 32'(hit2), 32'd0);
      chk("R5 no strobe sel", 32'(sel2), 32'd0);
      chk("R5 no strobe sel8", 32'(sel8), 32'd0);

      // R2: misaligned switches decode the aligned window.
      sw_base = 10'h30D;
      drive(10'h309, 1'b1, 1'b0);
      chk("R2 misaligned sw n2", 32'(hit2), 32'd1);
      chk("R2 misaligned sw sel2", 32'(sel2), 32'h1);
      drive(10'h31E, 1'b1, 1'b0);
      chk("R2 misaligned sw n8", 32'(hit8), 32'd1);
      chk("R2 misaligned sw sel8", 32'(sel8), 32'h80);
      check_all("R2");

      // R7: jumper off, long hit, no request.
      sw_base = BASE_DEFAULT;
      drive(10'h000, 1'b0, 1'b0);
      drive(10'h301, 1'b1, 1'b0);
      chk("R7 disabled c0", 32'(wr2), 32'd0);
      hold();
      chk("R7 disabled c1", 32'(wr2), 32'd0);

      // R9: two-cycle stretch from the start of a hit run.
      drive(10'h000, 1'b0, 1'b0);
      wait_en = 1'b1;
      drive(10'h301, 1'b1, 1'b0);
      chk("R9 wait c0", 32'(wr2), 32'd1);
      hold();
      chk("R9 wait c1", 32'(wr2), 32'd1);
      hold();
      chk("R9 wait c2 released", 32'(wr2), 32'd0);
      drive(10'h306, 1'b0, 1'b1);
      chk("R9 run continues across controllers", 32'(wr2), 32'd0);
      drive(10'h000, 1'b0, 1'b0);
      chk("R8 no hit no wait", 32'(wr2), 32'd0);
      drive(10'h304, 1'b0, 1'b1);
      chk("R9 restart after break", 32'(wr2), 32'd1);

      // R8: enabled, bus cycles elsewhere.
      drive(10'h000, 1'b0, 1'b0);
      drive(10'h3F0, 1'b1, 1'b0);
      chk("R8 foreign access no wait", 32'(wr2), 32'd0);
      hold();
      chk("R8 foreign access no wait later", 32'(wr8), 32'd0);

      // Random vectors held for one clock each; run counters model R9.
      drive(10'h000, 1'b0, 1'b0);
      hold();
      run2 = 0; run8 = 0;
      for (int n = 0; n < 600; n++) begin
         logic [9:0] a;
         bit rd, wr, h2, h8;
         if (n % 60 == 0) sw_base = ($urandom % 2) ? BASE_DEFAULT : 10'($urandom);
         if ($urandom % 2) a = {sw_base[9:5], 5'($urandom)};
         else              a = 10'($urandom);
         rd = 1'($urandom); wr = 1'($urandom);
         if (($urandom % 4) == 0) begin rd = 1'b0; wr = 1'b0; end
         wait_en = ($urandom % 4) != 0;
         drive(a, rd, wr);
         check_all("rand");
         h2 = f_hit(a, sw_base, rd, wr, 3);
         h8 = f_hit(a, sw_base, rd, wr, 5);
         chk("rand R7 R8 R9 wait2", 32'(wr2), 32'(wait_en && h2 && run2 < 2));
         chk("rand R7 R8 R9 wait8", 32'(wr8), 32'(wait_en && h8 && run8 < 2));
         run2 = h2 ? ((run2 < 2) ? run2 + 1 : 2) : 0;
         run8 = h8 ? ((run8 < 2) ? run8 + 1 : 2) : 0;
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule